// File: doc/BRIEF.md
# PWM DC-Offset Fault Monitor

This block watches the two drive signals of a bridge-tied PWM output stage and raises a fault when the speaker is seeing a sustained DC component. It treats each rising edge of the positive-side drive as the start of a switching period. Over each period it counts the clock cycles of the period, the cycles the positive drive is high and the cycles the negative drive is high. The signed difference of the two high times, compared with the period length, gives the differential duty cycle. A period whose differential duty goes past a fixed fraction of the period is an offset period, and its sign is its polarity.

Offset periods of one polarity add their lengths to a persistence accumulator. A period of the other polarity restarts the accumulator with its own length. A period that stays inside the threshold empties the accumulator. When the accumulated time goes strictly past a parameterised persistence limit, the fault output is set, and only reset clears it. Reset stands in for a supply cycle of the amplifier. Because every polarity run must last the whole window, very slow AC content trips the monitor as DC does, while audio-rate content never does.

The two drive inputs pass through a configurable synchroniser before measurement. A drive stuck at one level, which gives no edges at all, is still caught: the period closes on its own after a maximum length.

Top module: `pwm_dc_guard`

## Requirements
- R1: After reset, and while no persistence window has been completed, `dc_fault_o` is 0.
- R2: A period runs from one sampled rising edge of `pwm_pos_i` to the next. Let the period be L cycles, with P cycles where `pwm_pos_i` is high and N cycles where `pwm_neg_i` is high. The period is an offset period only when |P−N|·THR_DEN > THR_NUM·L. The boundary case is not an offset period: with defaults 14/100, a 57/43 split of a 100-cycle period is not an offset period, and 58/42 is.
- R3: An offset period has positive polarity when P > N and negative polarity when P < N.
- R4: Consecutive offset periods of the same polarity add their lengths L. The fault is set when the running sum goes strictly past PERSIST_CYC. `dc_fault_o` rises SYNC_STAGES+2 clock edges after the clock edge at which the rising edge that closes the deciding period is presented at the input.
- R5: An offset period whose polarity differs from the current run restarts the sum at its own length.
- R6: A period that is not an offset period resets the sum to zero.
- R7: Once set, `dc_fault_o` stays 1 whatever the inputs do, until `rst_ni` is asserted.
- R8: If no rising edge arrives for PER_MAX cycles, the period closes at length PER_MAX and is judged like any other. A drive stuck high, or a negative drive stuck high while the positive one stays low, therefore sets the fault.
- R9: Negative polarity sets the fault under the same timing as positive polarity.
- R10: Polarity alternating in runs longer than PERSIST_CYC sets the fault. Alternating in runs shorter than PERSIST_CYC never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the fault |
| pwm_pos_i | input | 1 | Positive-side bridge drive |
| pwm_neg_i | input | 1 | Negative-side bridge drive |
| dc_fault_o | output | 1 | Sticky DC-offset fault flag |

## Verification
A wrong period length or high-time count moves the threshold decision, so a boundary split such as 57/43 would turn into an offset period. The fault would then appear one period early, or one period late, exactly at the SYNC_STAGES+2 edge that follows a period close. A stale polarity or an accumulator that fails to clear shows up as a fault in the fast alternating or quiet-period sequences. That fault is visible within two edges after the close of the first period where the sum wrongly passes the limit. A lost sticky bit drops `dc_fault_o` during the balanced traffic that follows a trip.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    // Polarity of a judged switching period
    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_e;

endpackage

// File: rtl/pdg_sync.sv
module pdg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] d_i,
    output logic [1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0][1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = d_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= chain_d;
            end

            assign q_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pdg_duty_meter.sv
module pdg_duty_meter #(
    parameter int unsigned PER_MAX = 1023,
    parameter int unsigned PER_W   = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pos_i,
    input  logic             neg_i,
    output logic             vld_o,
    output logic [PER_W-1:0] len_o,
    output logic [PER_W-1:0] hi_pos_o,
    output logic [PER_W-1:0] hi_neg_o
);

    typedef struct packed {
        logic             pos_prev;
        logic             armed;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] hp;
        logic [PER_W-1:0] hn;
        logic             vld;
        logic [PER_W-1:0] r_len;
        logic [PER_W-1:0] r_hp;
        logic [PER_W-1:0] r_hn;
    } meter_t;

    meter_t s_d, s_q;
    logic             rise;
    logic [PER_W-1:0] cnt_inc;

    always_comb begin
        s_d          = s_q;
        s_d.pos_prev = pos_i;
        s_d.vld      = 1'b0;
        rise         = pos_i & ~s_q.pos_prev;
        cnt_inc      = s_q.cnt + PER_W'(1);

        if (rise) begin
            // close the running period and open a new one on this cycle
            if (s_q.armed && (s_q.cnt != '0)) begin
                s_d.vld   = 1'b1;
                s_d.r_len = s_q.cnt;
                s_d.r_hp  = s_q.hp;
                s_d.r_hn  = s_q.hn;
            end
            s_d.armed = 1'b1;
            s_d.cnt   = PER_W'(1);
            s_d.hp    = PER_W'(pos_i);
            s_d.hn    = PER_W'(neg_i);
        end else if (cnt_inc == PER_W'(PER_MAX)) begin
            // no edge for the longest allowed period: close it anyway
            s_d.vld   = 1'b1;
            s_d.r_len = PER_W'(PER_MAX);
            s_d.r_hp  = s_q.hp + PER_W'(pos_i);
            s_d.r_hn  = s_q.hn + PER_W'(neg_i);
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
            s_d.hp    = '0;
            s_d.hn    = '0;
        end else begin
            s_d.cnt = cnt_inc;
            s_d.hp  = s_q.hp + PER_W'(pos_i);
            s_d.hn  = s_q.hn + PER_W'(neg_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign vld_o    = s_q.vld;
    assign len_o    = s_q.r_len;
    assign hi_pos_o = s_q.r_hp;
    assign hi_neg_o = s_q.r_hn;

    // R2
    period_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> (len_o != '0) && (len_o <= PER_W'(PER_MAX)) &&
                  (hi_pos_o <= len_o) && (hi_neg_o <= len_o));

    // R8
    period_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |=> !vld_o);

endmodule

// File: rtl/pdg_offset_classifier.sv
module pdg_offset_classifier
    import pdg_pkg::*;
#(
    parameter int unsigned PER_W   = 10,
    parameter int unsigned THR_NUM = 14,
    parameter int unsigned THR_DEN = 100
) (
    input  logic [PER_W-1:0] len_i,
    input  logic [PER_W-1:0] hi_pos_i,
    input  logic [PER_W-1:0] hi_neg_i,
    output pol_e             pol_o
);

    localparam int unsigned PROD_W = PER_W + 16;

    logic [PER_W-1:0]  mag;
    logic [PROD_W-1:0] lhs, rhs;

    always_comb begin
        mag   = (hi_pos_i >= hi_neg_i) ? (hi_pos_i - hi_neg_i) : (hi_neg_i - hi_pos_i);
        lhs   = PROD_W'(mag) * PROD_W'(THR_DEN);
        rhs   = PROD_W'(THR_NUM) * PROD_W'(len_i);
        pol_o = POL_NONE;
        if (lhs > rhs) begin
            pol_o = (hi_pos_i > hi_neg_i) ? POL_POS : POL_NEG;
        end
    end

endmodule

// File: rtl/pdg_persist_timer.sv
module pdg_persist_timer
    import pdg_pkg::*;
#(
    parameter int unsigned PER_W       = 10,
    parameter int unsigned PERSIST_CYC = 42_000_000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vld_i,
    input  logic [PER_W-1:0] len_i,
    input  pol_e             pol_i,
    output logic             fault_o
);

    localparam int unsigned CAP   = PERSIST_CYC + 1;
    localparam int unsigned ACC_W = $clog2(PERSIST_CYC + 2);
    localparam int unsigned SUM_W = ((ACC_W > PER_W) ? ACC_W : PER_W) + 1;

    typedef struct packed {
        pol_e             pol;
        logic [ACC_W-1:0] acc;
        logic             fault;
    } run_t;

    run_t             s_d, s_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = SUM_W'(len_i) + ((pol_i == s_q.pol) ? SUM_W'(s_q.acc) : SUM_W'(0));
        if (vld_i) begin
            if (pol_i == POL_NONE) begin
                s_d.pol = POL_NONE;
                s_d.acc = '0;
            end else begin
                s_d.pol = pol_i;
                s_d.acc = (sum > SUM_W'(CAP)) ? ACC_W'(CAP) : ACC_W'(sum);
                if (sum > SUM_W'(PERSIST_CYC)) s_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{pol: POL_NONE, acc: '0, fault: 1'b0};
        else         s_q <= s_d;
    end

    assign fault_o = s_q.fault;

    // R7
    fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> fault_o);

    // R4
    fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> $past(vld_i && (pol_i != POL_NONE)));

    // R6
    quiet_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && (pol_i == POL_NONE)) |=> (s_q.acc == '0));

    // R5
    sign_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && (pol_i != POL_NONE) && (pol_i != s_q.pol)) |=>
            (s_q.pol == $past(pol_i)) && (s_q.acc <= ACC_W'(CAP)));

endmodule

// File: rtl/pwm_dc_guard.sv
module pwm_dc_guard
    import pdg_pkg::*;
#(
    parameter int unsigned PER_MAX     = 1023,
    parameter int unsigned PERSIST_CYC = 42_000_000,
    parameter int unsigned THR_NUM     = 14,
    parameter int unsigned THR_DEN     = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwm_pos_i,
    input  logic pwm_neg_i,
    output logic dc_fault_o
);

    localparam int unsigned PER_W = $clog2(PER_MAX + 1);

    logic [1:0]       drv_s;
    logic             per_vld;
    logic [PER_W-1:0] per_len, per_hp, per_hn;
    pol_e             per_pol;

    pdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({pwm_neg_i, pwm_pos_i}),
        .q_o    (drv_s)
    );

    pdg_duty_meter #(.PER_MAX(PER_MAX), .PER_W(PER_W)) u_meter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pos_i    (drv_s[0]),
        .neg_i    (drv_s[1]),
        .vld_o    (per_vld),
        .len_o    (per_len),
        .hi_pos_o (per_hp),
        .hi_neg_o (per_hn)
    );

    pdg_offset_classifier #(.PER_W(PER_W), .THR_NUM(THR_NUM), .THR_DEN(THR_DEN)) u_class (
        .len_i    (per_len),
        .hi_pos_i (per_hp),
        .hi_neg_i (per_hn),
        .pol_o    (per_pol)
    );

    pdg_persist_timer #(.PER_W(PER_W), .PERSIST_CYC(PERSIST_CYC)) u_persist (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vld_i   (per_vld),
        .len_i   (per_len),
        .pol_i   (per_pol),
        .fault_o (dc_fault_o)
    );

    // R3
    polarity_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_vld && (per_pol != POL_NONE)) |-> (per_hp != per_hn));

endmodule

// File: tb/sim_pwm_dc_guard.sv
module sim_pwm_dc_guard;

    localparam int unsigned PER_MAX = 255;
    localparam int unsigned PERSIST = 600;
    localparam int unsigned S       = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p = 1'b0;
    logic n = 1'b0;
    logic fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int  m_pol = 0;
    int  m_acc = 0;
    bit  m_fault = 1'b0;
    bit  pend = 1'b0;
    int  pend_t, pend_hp, pend_hn;

    always #2.5 clk = ~clk;

    pwm_dc_guard #(.PER_MAX(PER_MAX), .PERSIST_CYC(PERSIST), .THR_NUM(14),
                   .THR_DEN(100), .SYNC_STAGES(S)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .pwm_pos_i(p), .pwm_neg_i(n), .dc_fault_o(fault));

    function automatic int classify(int t, int hp, int hn);
        int d = hp - hn;
        int mag = (d < 0) ? -d : d;
        if (mag * 100 > 14 * t) return (d > 0) ? 1 : 2;
        return 0;
    endfunction

    task automatic model_apply(int t, int hp, int hn);
        int c = classify(t, hp, hn);
        if (c == 0) begin m_pol = 0; m_acc = 0; end
        else begin
            if (c == m_pol) m_acc = m_acc + t; else m_acc = t;
            m_pol = c;
            if (m_acc > int'(PERSIST)) m_fault = 1'b1;
        end
    endtask

    task automatic check(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dc_fault_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; p = 1'b0; n = 1'b0;
        repeat (3) @(negedge clk);
        m_pol = 0; m_acc = 0; m_fault = 1'b0; pend = 1'b0;
        check(fault, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(fault, 1'b0, "R1 after reset");
    endtask

    // Drives one period; checks the exact edge at which the previous period's verdict lands (R4)
    task automatic drive_period(int t, int hp, int hn, string req);
        bit old_f = m_fault;
        if (pend) model_apply(pend_t, pend_hp, pend_hn);
        pend = 1'b1; pend_t = t; pend_hp = hp; pend_hn = hn;
        for (int i = 0; i < t; i++) begin
            p = (i < hp); n = (i < hn);
            @(negedge clk);
            if (i == int'(S)) check(fault, old_f, {req, " R4 before latency"});
            if (i == int'(S) + 1) check(fault, m_fault, {req, " R4 at latency"});
        end
    endtask

    task automatic run_const(int cnt, int t, int hp, int hn, string req);
        for (int k = 0; k < cnt; k++) drive_period(t, hp, hn, req);
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // R2: exact 14 % boundary is not an offset period, either sign
        run_const(10, 100, 57, 43, "R2 boundary pos");
        run_const(10, 100, 43, 57, "R2 boundary neg");
        run_const(1, 100, 50, 50, "R2 flush");
        check(fault, 1'b0, "R2 boundary no fault");

        // R2/R3/R4: 58/42 counts; 6 periods sum to 600 (not past), 7th trips
        do_reset();
        run_const(7, 100, 58, 42, "R4 accumulate");
        run_const(1, 100, 50, 50, "R4 trip");
        check(fault, 1'b1, "R4 fault after 7 periods");
        // R7: balanced traffic does not clear it
        run_const(6, 40, 20, 20, "R7 sticky");
        check(fault, 1'b1, "R7 still set");
        do_reset();
        check(fault, 1'b0, "R1 reset clears");

        // R9: negative polarity, same timing
        run_const(7, 100, 40, 60, "R9 negative");
        run_const(1, 100, 50, 50, "R9 trip");
        check(fault, 1'b1, "R9 negative fault");

        // R5: sign change restarts the sum
        do_reset();
        run_const(5, 100, 80, 10, "R5 pos");
        run_const(5, 100, 10, 80, "R5 neg");
        run_const(6, 100, 80, 10, "R5 pos again");
        run_const(1, 100, 80, 10, "R5 seventh");
        check(fault, 1'b0, "R5 no fault yet");
        run_const(1, 100, 50, 50, "R5 trip");
        check(fault, 1'b1, "R5 fault after restart run");

        // R6: a quiet period empties the sum
        do_reset();
        run_const(6, 100, 80, 10, "R6 pos");
        run_const(1, 100, 50, 50, "R6 quiet");
        run_const(6, 100, 80, 10, "R6 pos again");
        run_const(1, 100, 50, 50, "R6 quiet2");
        check(fault, 1'b0, "R6 no fault");

        // R10: fast alternation never trips, slow alternation does
        do_reset();
        for (int k = 0; k < 6; k++) begin
            run_const(5, 100, 75, 25, "R10 fast pos");
            run_const(5, 100, 25, 75, "R10 fast neg");
        end
        check(fault, 1'b0, "R10 fast alternation");
        do_reset();
        run_const(8, 100, 75, 25, "R10 slow pos");
        run_const(8, 100, 25, 75, "R10 slow neg");
        check(fault, 1'b1, "R10 slow alternation");

        // R8: stuck positive drive, no further edges
        do_reset();
        p = 1'b1; n = 1'b0;
        repeat (700) @(negedge clk);
        check(fault, 1'b0, "R8 stuck high before window");
        repeat (100) @(negedge clk);
        check(fault, 1'b1, "R8 stuck high trips");
        // R8/R9: stuck negative drive, positive never rises
        do_reset();
        p = 1'b0; n = 1'b1;
        repeat (700) @(negedge clk);
        check(fault, 1'b0, "R8 stuck neg before window");
        repeat (100) @(negedge clk);
        check(fault, 1'b1, "R8 stuck neg trips");

        // Random traffic with polarity runs, against the model
        do_reset();
        begin
            int bias = 1;
            int after = 0;
            for (int k = 0; k < 320; k++) begin
                int t = $urandom_range(60, 20);
                int hp, hn;
                if ($urandom_range(19, 0) == 0) bias = $urandom_range(2, 0);
                if ($urandom_range(7, 0) == 0 || bias == 0) begin
                    hp = $urandom_range(t - 1, 1); hn = $urandom_range(t - 1, 0);
                end else if (bias == 1) begin
                    hp = $urandom_range(t - 1, (t * 7) / 10); hn = $urandom_range(t / 3, 0);
                end else begin
                    hp = $urandom_range(t / 3, 1); hn = $urandom_range(t - 1, (t * 7) / 10);
                end
                drive_period(t, hp, hn, "R2 R3 R4 R5 R6 random");
                if (m_fault) after++;
                if (after > 4) begin
                    check(fault, 1'b1, "R7 random sticky");
                    do_reset();
                    after = 0;
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule